// File: doc/BRIEF.md
# Framed SPI Register Slave

This block is an SPI slave (clock idle low, data sampled on the rising SCLK edge and changed on the falling edge) that lets a host read and write a bank of 32-bit registers. Every transaction opens with a 32-bit header: an opcode byte, a 16-bit byte address and a word count. The header is followed by that many 32-bit data words, all sent MSB first. While the header goes in, the slave shifts its fault-flag byte out on MISO. The host therefore learns at the start of each access whether the previous one was accepted.

The slave counts SCLK edges between the falling and rising edges of chip-select. A transaction counts as correctly framed only if the clock count is a whole number of words and the number of data words equals the header's count. Write data waits in a staging buffer and reaches the register bank only when chip-select rises on a correctly framed write. Any framing fault discards the buffered data and sets a sticky error flag. The host clears that flag through a write-one-to-clear status register. SCLK, chip-select and MOSI are taken as already synchronous to the system clock, and the block oversamples them.

Top module: `spi_regslave`

## Requirements
- R1: Every transaction's first 32 MISO bits are the fault byte followed by 24 zeros. Bit 7 of that byte is the global fault summary and bit 3 is the framing-error flag, so a clean state reads 0x00000000 and a pending framing error reads 0x88000000.
- R2: Opcode 0x61 (header bits 31:24) with a correctly framed transaction writes data word k to the register at word index (address[15:2] + k) when chip-select rises. Address bits 1:0 are ignored. Indices with no register are skipped.
- R3: Opcode 0x41 returns, for data word k, the value at word index (address[15:2] + k), MSB first. This applies to every complete word clocked, including words past the count. Unmapped indices return zero and the status index returns the status word.
- R4: A transaction whose SCLK rising-edge count is not a multiple of 32 sets the framing-error flag and changes no register.
- R5: A transaction with fewer or more data words than the count field (header bits 7:0) sets the framing-error flag. A write framed this way changes no register.
- R6: A count of zero, or a write count above MAX_WORDS, is a framing error, and the write is discarded. A write of exactly MAX_WORDS words is accepted.
- R7: The framing-error flag stays set across any number of later transactions. Only a correctly framed write to byte address STAT_ADDR whose bit 3 is 1 clears it, and writing 0 there leaves it set. The status word reads {24'b0, fault byte}.
- R8: For any opcode other than 0x41, MISO carries zeros after the header. Opcodes other than 0x61 change no register.
- R9: After reset all registers read zero, the framing-error flag is clear and MISO is low.
- R10: MISO is low whenever chip-select has been high for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock, idle low, synchronous to clk |
| spi_cs_n | input | 1 | Active-low chip-select; its rising edge ends a transaction |
| spi_mosi | input | 1 | Serial data from the host, sampled on SCLK rising edges |
| spi_miso | output | 1 | Serial data to the host, updated after SCLK falling edges |

## Verification
The checks take for granted that SCLK, chip-select and MOSI change only in step with the system clock. They also assume each level lasts at least two clocks, so that every SCLK edge is seen once, and that chip-select stays low for at least a clock after it falls. The stimulus drives all three pins on the falling clock edge. It holds each SCLK phase for two or more clocks and keeps several clocks between chip-select edges and the first or last SCLK edge, so the edge detection never merges or misses an edge.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam logic [7:0] OPC_WRITE = 8'h61;
    localparam logic [7:0] OPC_READ  = 8'h41;

    localparam int FLAG_GLOBAL_BIT = 7;
    localparam int FLAG_FRAME_BIT  = 3;

    localparam int WORD_BITS = 32;
    localparam int IDX_W     = 14;   // word index = byte address [15:2]

    typedef struct packed {
        logic [7:0]       opcode;
        logic [IDX_W-1:0] widx;
        logic [7:0]       count;
    } hdr_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } access_e;

    function automatic access_e decode_access(input logic [7:0] op);
        access_e a;
        case (op)
            OPC_WRITE: a = ACC_WRITE;
            OPC_READ:  a = ACC_READ;
            default:   a = ACC_NONE;
        endcase
        return a;
    endfunction

    function automatic logic [7:0] fault_byte(input logic frame_err);
        logic [7:0] b;
        b = '0;
        b[FLAG_FRAME_BIT]  = frame_err;
        b[FLAG_GLOBAL_BIT] = |{frame_err};
        return b;
    endfunction

endpackage

// File: rtl/spi_regslave_phy.sv
module spi_regslave_phy
    import spi_regslave_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic [7:0]       hdr_flags,
    input  logic [31:0]      next_word,
    output logic             spi_miso,
    output logic             cs_fall,
    output logic             cs_rise,
    output logic             word_done,
    output logic [31:0]      rx_word,
    output logic [CNT_W-1:0] words,
    output logic             aligned
);

    localparam logic [CNT_W-1:0] WCNT_MAX = '1;

    logic             sclk_q;
    logic             cs_q;
    logic [4:0]       bitpos;
    logic [CNT_W-1:0] wcnt;
    logic [30:0]      rx_sr;
    logic [31:0]      tx_sr;
    logic             in_xact;
    logic             sck_rise;
    logic             sck_fall;

    assign in_xact   = !cs_q && !spi_cs_n;
    assign cs_fall   = cs_q && !spi_cs_n;
    assign cs_rise   = !cs_q && spi_cs_n;
    assign sck_rise  = in_xact && spi_sclk && !sclk_q;
    assign sck_fall  = in_xact && !spi_sclk && sclk_q;
    assign word_done = sck_rise && (bitpos == 5'd31);
    assign rx_word   = {rx_sr, spi_mosi};
    assign words     = wcnt;
    assign aligned   = (bitpos == 5'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            bitpos <= '0;
            wcnt   <= '0;
            rx_sr  <= '0;
            tx_sr  <= '0;
        end else begin
            sclk_q <= spi_sclk;
            cs_q   <= spi_cs_n;
            if (cs_fall) begin
                bitpos <= '0;
                wcnt   <= '0;
                tx_sr  <= {hdr_flags, 24'h0};
            end else begin
                if (sck_rise) begin
                    rx_sr  <= rx_word[30:0];
                    bitpos <= bitpos + 5'd1;
                    if (bitpos == 5'd31 && wcnt != WCNT_MAX) begin
                        wcnt <= wcnt + CNT_W'(1);
                    end
                end
                if (sck_fall) begin
                    if (bitpos == 5'd0 && wcnt != '0) begin
                        tx_sr <= next_word;
                    end else begin
                        tx_sr <= {tx_sr[30:0], 1'b0};
                    end
                end
            end
        end
    end

    assign spi_miso = !cs_q && tx_sr[31];

endmodule

// File: rtl/spi_regslave_xact.sv
module spi_regslave_xact
    import spi_regslave_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             word_done,
    input  logic [31:0]      rx_word,
    input  logic [CNT_W-1:0] words,
    input  logic             aligned,
    input  logic             stat_w1c,
    output access_e          acc,
    output logic [IDX_W-1:0] base_idx,
    output logic [7:0]       count,
    output logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      stage_q [MAX_WORDS],
    output logic             commit,
    output logic             err_set,
    output logic             spi_err,
    output logic [7:0]       flags
);

    localparam int               SW      = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(MAX_WORDS);
    localparam logic [7:0]       DEPTH_L = 8'(MAX_WORDS);

    hdr_t             hdr_q;
    logic [CNT_W-1:0] data_idx;
    logic [CNT_W-1:0] want_words;
    logic             frame_ok;

    assign acc        = decode_access(hdr_q.opcode);
    assign base_idx   = hdr_q.widx;
    assign count      = hdr_q.count;
    assign data_idx   = words - CNT_W'(1);
    assign want_words = {{(CNT_W-8){1'b0}}, hdr_q.count} + CNT_W'(1);
    assign rd_idx     = hdr_q.widx + {{(IDX_W-CNT_W){1'b0}}, data_idx};

    assign frame_ok = aligned
                   && (hdr_q.count != 8'd0)
                   && (words == want_words)
                   && !(acc == ACC_WRITE && hdr_q.count > DEPTH_L);

    assign commit  = cs_rise && frame_ok && (acc == ACC_WRITE);
    assign err_set = cs_rise && !frame_ok;
    assign flags   = fault_byte(spi_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q   <= '0;
            spi_err <= 1'b0;
            for (int i = 0; i < MAX_WORDS; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            if (cs_fall) begin
                hdr_q <= '0;
            end else if (word_done) begin
                if (words == '0) begin
                    hdr_q <= '{opcode: rx_word[31:24],
                               widx:   rx_word[23:10],
                               count:  rx_word[7:0]};
                end else if (data_idx < DEPTH_C) begin
                    stage_q[data_idx[SW-1:0]] <= rx_word;
                end
            end
            if (err_set) begin
                spi_err <= 1'b1;
            end else if (stat_w1c) begin
                spi_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_regslave_regfile.sv
module spi_regslave_regfile
    import spi_regslave_pkg::*;
#(
    parameter int               NREGS     = 8,
    parameter int               MAX_WORDS = 4,
    parameter logic [IDX_W-1:0] STAT_IDX  = 14'd16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic [IDX_W-1:0]      base_idx,
    input  logic [7:0]            count,
    input  logic [31:0]           stage [MAX_WORDS],
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [7:0]            flags,
    output logic [31:0]           rd_data,
    output logic                  stat_w1c,
    output logic [NREGS*32-1:0]   regs_flat
);

    localparam int SW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    logic [IDX_W-1:0] cnt_ext;
    logic [IDX_W-1:0] stat_off;

    assign cnt_ext  = {{(IDX_W-8){1'b0}}, count};
    assign stat_off = STAT_IDX - base_idx;
    assign stat_w1c = commit && (stat_off < cnt_ext)
                   && stage[stat_off[SW-1:0]][FLAG_FRAME_BIT];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [IDX_W-1:0] off;
        logic             hit;
        logic [31:0]      r_q;

        assign off = IDX_W'(g) - base_idx;
        assign hit = commit && (off < cnt_ext);

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (hit) begin
                r_q <= stage[off[SW-1:0]];
            end
        end

        assign regs_flat[g*32 +: 32] = r_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == STAT_IDX) begin
            rd_data = {24'h0, flags};
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (rd_idx == IDX_W'(i)) begin
                    rd_data = regs_flat[i*32 +: 32];
                end
            end
        end
    end

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int          NREGS     = 8,
    parameter int          MAX_WORDS = 4,
    parameter logic [15:0] STAT_ADDR = 16'h0040
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);

    localparam int               CNT_W    = 9;
    localparam logic [IDX_W-1:0] STAT_IDX = STAT_ADDR[15:2];

    logic                  cs_fall;
    logic                  cs_rise;
    logic                  word_done;
    logic [31:0]           rx_word;
    logic [CNT_W-1:0]      words;
    logic                  aligned;
    logic [7:0]            flags;
    logic [31:0]           next_word;
    logic [31:0]           rd_data;
    access_e               acc;
    logic [IDX_W-1:0]      base_idx;
    logic [7:0]            count;
    logic [IDX_W-1:0]      rd_idx;
    logic [31:0]           stage [MAX_WORDS];
    logic                  commit;
    logic                  err_set;
    logic                  spi_err;
    logic                  stat_w1c;
    logic [NREGS*32-1:0]   regs_flat;

    assign next_word = (acc == ACC_READ) ? rd_data : '0;

    spi_regslave_phy #(.CNT_W(CNT_W)) u_phy (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .hdr_flags (flags),
        .next_word (next_word),
        .spi_miso  (spi_miso),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .word_done (word_done),
        .rx_word   (rx_word),
        .words     (words),
        .aligned   (aligned)
    );

    spi_regslave_xact #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_xact (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .word_done (word_done),
        .rx_word   (rx_word),
        .words     (words),
        .aligned   (aligned),
        .stat_w1c  (stat_w1c),
        .acc       (acc),
        .base_idx  (base_idx),
        .count     (count),
        .rd_idx    (rd_idx),
        .stage_q   (stage),
        .commit    (commit),
        .err_set   (err_set),
        .spi_err   (spi_err),
        .flags     (flags)
    );

    spi_regslave_regfile #(
        .NREGS     (NREGS),
        .MAX_WORDS (MAX_WORDS),
        .STAT_IDX  (STAT_IDX)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .base_idx  (base_idx),
        .count     (count),
        .stage     (stage),
        .rd_idx    (rd_idx),
        .flags     (flags),
        .rd_data   (rd_data),
        .stat_w1c  (stat_w1c),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
    parameter int NREGS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                spi_cs_n,
    input logic                spi_miso,
    input logic                commit,
    input logic                err_set,
    input logic                stat_w1c,
    input logic                spi_err,
    input logic [NREGS*32-1:0] regs_flat
);

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso);                       // R10

    AST_HDR_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |=> (spi_miso == spi_err));                         // R1

    AST_NO_COMMIT_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(commit && err_set));                                             // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs_flat));                                   // R5

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        err_set |=> spi_err);                                              // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (spi_err && !stat_w1c) |=> spi_err);                               // R7

endmodule

bind spi_regslave spi_regslave_chk #(.NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .commit    (commit),
    .err_set   (err_set),
    .stat_w1c  (stat_w1c),
    .spi_err   (spi_err),
    .regs_flat (regs_flat)
);

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;
    import spi_regslave_pkg::*;

    localparam int          NREGS     = 8;
    localparam int          MAXW      = 4;
    localparam logic [15:0] STAT_ADDR = 16'h0040;
    localparam int          STAT_IDX  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    always #2.5 clk = ~clk;

    spi_regslave #(
        .NREGS     (NREGS),
        .MAX_WORDS (MAXW),
        .STAT_ADDR (STAT_ADDR)
    ) u_spi_regslave (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] mreg [NREGS];
    bit          merr;
    logic [31:0] txw [16];
    logic [31:0] rxw [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mval(input int idx_in);
        int idx;
        idx = idx_in & 32'h3FFF;
        if (idx == STAT_IDX) return merr ? 32'h0000_0088 : 32'h0;
        if (idx < NREGS) return mreg[idx];
        return 32'h0;
    endfunction

    task automatic xfer(input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            int w;
            int p;
            w = b / 32;
            p = 31 - (b % 32);
            mosi = txw[w][p];
            repeat (2) @(negedge clk);
            rxw[w][p] = miso;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // htag names the header check, dtag the data-word checks
    task automatic run(input logic [7:0] op, input logic [15:0] addr, input logic [7:0] cnt,
                       input int nbits, input string htag, input string dtag);
        int          nw;
        bit          ok;
        logic [31:0] exp_hdr;
        logic [31:0] exp_d [16];
        nw = nbits / 32;
        txw[0] = {op, addr, cnt};
        ok = (nbits % 32 == 0) && (cnt != 0) && (nw == int'(cnt) + 1)
             && !(op == OPC_WRITE && int'(cnt) > MAXW);
        exp_hdr = merr ? 32'h8800_0000 : 32'h0;
        for (int k = 0; k < 16; k++) begin
            exp_d[k] = 32'h0;
            rxw[k]   = 32'h0;
        end
        for (int k = 0; k < nw - 1; k++) begin
            exp_d[k] = (op == OPC_READ) ? mval(int'(addr >> 2) + k) : 32'h0;
        end
        xfer(nbits);
        if (nbits >= 32) chk(htag, rxw[0], exp_hdr);
        for (int k = 0; k < nw - 1; k++) begin
            chk(dtag, rxw[k + 1], exp_d[k]);
        end
        if (!ok) begin
            merr = 1'b1;
        end else if (op == OPC_WRITE) begin
            for (int k = 0; k < int'(cnt); k++) begin
                int idx;
                idx = (int'(addr >> 2) + k) & 32'h3FFF;
                if (idx < NREGS) mreg[idx] = txw[k + 1];
                if (idx == STAT_IDX && txw[k + 1][3]) merr = 1'b0;
            end
        end
    endtask

    task automatic verify_all(input string tag);
        run(OPC_READ, 16'h0000, 8'(NREGS), 32 * (NREGS + 1), tag, tag);
        run(OPC_READ, STAT_ADDR, 8'd1, 64, tag, tag);
    endtask

    task automatic clear_err(input string tag);
        txw[1] = 32'h0000_0008;
        run(OPC_WRITE, STAT_ADDR, 8'd1, 64, tag, tag);
        verify_all(tag);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) mreg[i] = 32'h0;
        merr = 1'b0;
        for (int i = 0; i < 16; i++) txw[i] = 32'h0;

        repeat (5) @(negedge clk);
        chk("R9", {31'h0, miso}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", {31'h0, miso}, 32'h0);
        verify_all("R9");

        // write sweep over every base index with 1..3 words
        for (int base = 0; base < NREGS; base++) begin
            int cnt;
            cnt = 1 + (base % 3);
            for (int k = 0; k < cnt; k++) begin
                txw[k + 1] = (32'h1111_0000 * (base + 1)) ^ (32'h0000_0101 * (k + 3)) ^ 32'h00A5_5A00;
            end
            run(OPC_WRITE, 16'(base * 4), 8'(cnt), 32 * (cnt + 1), "R1", "R8");
            verify_all("R2");
        end
        // low address bits ignored
        txw[1] = 32'hDEAD_BEEF;
        run(OPC_WRITE, 16'h0017, 8'd1, 64, "R1", "R8");
        verify_all("R2");

        // reads: offset burst, unmapped, across the end of the bank
        run(OPC_READ, 16'h0004, 8'd3, 128, "R1", "R3");
        run(OPC_READ, 16'h0028, 8'd2, 96, "R1", "R3");
        run(OPC_READ, 16'h0018, 8'd4, 160, "R1", "R3");
        run(OPC_READ, 16'h0006, 8'd1, 64, "R1", "R3");

        // R4: clock count not a multiple of 32
        txw[1] = 32'hFFFF_0000;
        run(OPC_WRITE, 16'h0008, 8'd1, 40, "R1", "R8");
        verify_all("R4");
        clear_err("R7");
        txw[1] = 32'h0BAD_0BAD;
        run(OPC_WRITE, 16'h0000, 8'd1, 63, "R1", "R8");
        verify_all("R4");
        clear_err("R7");
        txw[1] = 32'h1234_5678;
        run(OPC_WRITE, 16'h000C, 8'd1, 65, "R1", "R8");
        verify_all("R4");

        // R7: sticky, writing zero to bit 3 keeps it
        txw[1] = 32'hFFFF_FFF7;
        run(OPC_WRITE, STAT_ADDR, 8'd1, 64, "R7", "R8");
        verify_all("R7");
        clear_err("R7");

        // R5: too few and too many words
        txw[1] = 32'hAAAA_5555; txw[2] = 32'h5555_AAAA;
        run(OPC_WRITE, 16'h0004, 8'd2, 64, "R1", "R8");
        verify_all("R5");
        clear_err("R7");
        run(OPC_WRITE, 16'h0004, 8'd1, 96, "R1", "R8");
        verify_all("R5");
        clear_err("R7");
        run(OPC_WRITE, 16'h0004, 8'd1, 32, "R1", "R8");
        verify_all("R5");
        clear_err("R7");
        run(OPC_READ, 16'h0008, 8'd1, 96, "R5", "R3");
        verify_all("R5");
        clear_err("R7");

        // R6: zero count and oversized writes
        run(OPC_WRITE, 16'h0000, 8'd0, 32, "R1", "R8");
        verify_all("R6");
        clear_err("R7");
        txw[1] = 32'h7777_0001;
        run(OPC_WRITE, 16'h0000, 8'd0, 64, "R1", "R8");
        verify_all("R6");
        clear_err("R7");
        for (int k = 0; k < MAXW + 1; k++) txw[k + 1] = 32'hC0DE_0000 + k;
        run(OPC_WRITE, 16'h0000, 8'(MAXW + 1), 32 * (MAXW + 2), "R1", "R8");
        verify_all("R6");
        clear_err("R7");
        for (int k = 0; k < MAXW; k++) txw[k + 1] = 32'hF00D_0000 + k;
        run(OPC_WRITE, 16'h0004, 8'(MAXW), 32 * (MAXW + 1), "R1", "R8");
        verify_all("R6");

        // R8: foreign opcodes
        txw[1] = 32'hFFFF_FFFF;
        run(8'h00, 16'h0000, 8'd1, 64, "R1", "R8");
        run(8'h60, 16'h0004, 8'd1, 64, "R1", "R8");
        run(8'h62, 16'h0008, 8'd1, 64, "R1", "R8");
        run(8'h40, 16'h000C, 8'd1, 64, "R1", "R8");
        run(8'hFF, 16'h0010, 8'd1, 64, "R1", "R8");
        verify_all("R8");

        // R7: multi-word write spanning the status word clears the flag
        run(OPC_WRITE, 16'h0000, 8'd1, 50, "R1", "R8");
        txw[1] = 32'h1; txw[2] = 32'h2; txw[3] = 32'h0000_0008; txw[4] = 32'h4;
        run(OPC_WRITE, 16'h0038, 8'd4, 160, "R7", "R8");
        verify_all("R7");

        // R10: idle MISO
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R10", {31'h0, miso}, 32'h0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule